// File: doc/BRIEF.md
# Delay-Slot Control-Transfer Resolver

This block settles a control-transfer instruction once its outcome is known, in a core whose branches carry an architectural delay slot. On each resolve strobe it takes the branch address, the resolved destination (the branch target when taken, the fall-through when not), the actual and predicted direction, the annul bit, a three-bit kind code, a flag saying the branch was fetched without any prediction, and a flag saying whether the delay-slot instruction has already entered fetch. One cycle later it presents a registered verdict: a checkpoint-release strobe for a correct guess, a recovery strobe for a wrong one, a redirect strobe with a fresh PC/NPC pair, and a fetch-unstall pulse when an unpredicted branch is settled.

The redirect pair is not always "destination, destination plus one instruction". When the delay slot is still to be fetched, or when an annulling conditional branch was guessed not-taken, the slot must still run, so the pair becomes "branch address plus one instruction, destination". Two small state machines carry the control. The fetch-mode machine has states MODE_PREDICT and MODE_UNPRED; the transition MODE_PREDICT to MODE_UNPRED fires on the mode-enter input, MODE_UNPRED to MODE_PREDICT fires on the resolve of an unpredicted branch, and in any other case the state is held. The verdict selector picks one of VERD_NONE, VERD_GOOD, VERD_BAD and VERD_UNPRED for every resolve, and an address former picks between the ADDR_SLOT and ADDR_TARGET pair layouts.

Top module: `cxr_resolver`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all strobes are low, both redirect addresses read zero and the unpredicted-fetch indication is low.
- R2: Every output is registered: a resolve sampled at one clock edge shows its result right after that edge; the strobes are single-cycle pulses, no strobe rises without a resolve, and the redirect addresses keep their last value when no redirect occurs.
- R3: A resolve with the unpredicted flag set and with the annul bit set or the delay slot already fetched redirects to PC = destination, NPC = destination + 4.
- R4: A resolve with the unpredicted flag set, annul bit clear and delay slot not yet fetched redirects to PC = branch address + 4, NPC = destination, whatever the kind code.
- R5: An unpredicted resolve pulses the unstall output, raises neither prediction strobe, and returns the fetch mode to predicting.
- R6: Kind codes 2 and 3 (direct unconditional) without the unpredicted flag skip the prediction check: no redirect, release or recovery strobe, even when the directions differ.
- R7: For kind codes 0 (conditional), 1 (checked jump), 4 (return) and 5 to 7 (treated as 1), matching actual and predicted directions give a release strobe and no redirect.
- R8: A misprediction whose delay slot is not yet fetched redirects to PC = branch address + 4, NPC = destination, with the recovery strobe.
- R9: A misprediction of an annulling conditional branch (kind 0) guessed not-taken redirects to PC = branch address + 4, NPC = destination, with the recovery strobe.
- R10: Any other misprediction redirects to PC = destination, NPC = destination + 4, with the recovery strobe.
- R11: A return (kind 4) follows the same check and misprediction rules, but its annul bit never selects the R9 layout, since that rule covers only kind 0.
- R12: The mode-enter input sets the unpredicted-fetch indication on the next cycle; if it coincides with an unpredicted resolve, the indication stays set while the unstall pulse still fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_enter | input | 1 | Fetch has issued a branch without prediction |
| rsv_valid | input | 1 | Resolve strobe, at most one per cycle |
| br_pc | input | ADDR_W | Address of the resolving branch |
| br_dest | input | ADDR_W | Resolved next address (target or fall-through) |
| dir_taken | input | 1 | Actual direction |
| dir_guess | input | 1 | Predicted direction |
| annul_bit | input | 1 | Branch annuls its delay slot |
| xfer_kind | input | 3 | 0 conditional, 1 checked jump, 2/3 direct unchecked, 4 return |
| was_unpred | input | 1 | Branch was fetched without prediction |
| slot_fetched | input | 1 | Delay-slot instruction already fetched |
| redirect | output | 1 | Fetch must restart at new_pc/new_npc |
| new_pc | output | ADDR_W | Redirect PC |
| new_npc | output | ADDR_W | Redirect NPC |
| ckpt_release | output | 1 | Prediction correct, free its checkpoint |
| ckpt_recover | output | 1 | Prediction wrong, roll back to its checkpoint |
| fetch_unstall | output | 1 | Unpredicted branch settled, fetch may resume |
| unpred_active | output | 1 | Fetch is in unpredicted mode |

## Verification
The bench builds the block with the default 32-bit address and 4-byte instruction step, which puts the "plus one instruction" offsets at small, readable values and lets the branch and destination addresses of each vector be told apart from each other. Every kind code, both flags and the annul bit are combined across a vector table so each pair layout is reached from more than one route, and the mode machine is driven through both transitions, including the enter-and-clear collision.

// File: rtl/cxr_pkg.sv
package cxr_pkg;

    localparam logic [2:0] KIND_COND     = 3'd0;
    localparam logic [2:0] KIND_JUMP     = 3'd1;
    localparam logic [2:0] KIND_DIRECT_A = 3'd2;
    localparam logic [2:0] KIND_DIRECT_B = 3'd3;
    localparam logic [2:0] KIND_RETURN   = 3'd4;

    typedef enum logic [1:0] {
        VERD_NONE   = 2'd0,
        VERD_GOOD   = 2'd1,
        VERD_BAD    = 2'd2,
        VERD_UNPRED = 2'd3
    } verdict_e;

    typedef enum logic {
        MODE_PREDICT = 1'b0,
        MODE_UNPRED  = 1'b1
    } fetch_mode_e;

    typedef enum logic {
        ADDR_TARGET = 1'b0,
        ADDR_SLOT   = 1'b1
    } addr_form_e;

endpackage

// File: rtl/cxr_decide.sv
module cxr_decide
    import cxr_pkg::*;
(
    input  logic       was_unpred,
    input  logic       slot_fetched,
    input  logic       annul_bit,
    input  logic [2:0] xfer_kind,
    input  logic       dir_taken,
    input  logic       dir_guess,
    output verdict_e   verdict,
    output addr_form_e form
);

    logic skip_check;
    logic wrong_dir;
    logic keep_slot;

    always_comb begin
        skip_check = (xfer_kind == KIND_DIRECT_A) || (xfer_kind == KIND_DIRECT_B);
        wrong_dir  = dir_taken != dir_guess;
        // an annulling conditional guessed not-taken still owes its slot
        keep_slot  = !slot_fetched ||
                     (annul_bit && (xfer_kind == KIND_COND) && !dir_guess);
    end

    always_comb begin
        verdict = VERD_NONE;
        form    = ADDR_TARGET;
        unique case ({was_unpred, skip_check})
            2'b10, 2'b11: begin
                verdict = VERD_UNPRED;
                form    = (annul_bit || slot_fetched) ? ADDR_TARGET : ADDR_SLOT;
            end
            2'b01: begin
                verdict = VERD_NONE;
            end
            default: begin
                if (wrong_dir) begin
                    verdict = VERD_BAD;
                    form    = keep_slot ? ADDR_SLOT : ADDR_TARGET;
                end else begin
                    verdict = VERD_GOOD;
                end
            end
        endcase
    end

    always_comb begin
        AST_SKIP_IS_SILENT: assert (!(skip_check && !was_unpred) || verdict == VERD_NONE); // R6
    end

endmodule

// File: rtl/cxr_addr_gen.sv
module cxr_addr_gen
    import cxr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [ADDR_W-1:0] br_pc,
    input  logic [ADDR_W-1:0] br_dest,
    input  addr_form_e        form,
    output logic [ADDR_W-1:0] pc_out,
    output logic [ADDR_W-1:0] npc_out
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    logic [ADDR_W-1:0] slot_pc;
    logic [ADDR_W-1:0] dest_next;

    always_comb begin
        slot_pc   = br_pc + STEP;
        dest_next = br_dest + STEP;
        unique case (form)
            ADDR_SLOT: begin
                pc_out  = slot_pc;
                npc_out = br_dest;
            end
            ADDR_TARGET: begin
                pc_out  = br_dest;
                npc_out = dest_next;
            end
            default: begin
                pc_out  = br_dest;
                npc_out = dest_next;
            end
        endcase
    end

endmodule

// File: rtl/cxr_mode_fsm.sv
module cxr_mode_fsm
    import cxr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode_enter,
    input  logic mode_clear,
    output logic active
);

    fetch_mode_e state_q;
    fetch_mode_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_PREDICT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_PREDICT: if (mode_enter) state_d = MODE_UNPRED;
            MODE_UNPRED:  if (mode_clear && !mode_enter) state_d = MODE_PREDICT;
            default:      state_d = MODE_PREDICT;
        endcase
        active = (state_q == MODE_UNPRED);
    end

    AST_MODE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_clear && !mode_enter) |=> !active); // R5

    AST_MODE_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        mode_enter |=> active); // R12

endmodule

// File: rtl/cxr_resolver.sv
module cxr_resolver
    import cxr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_enter,
    input  logic              rsv_valid,
    input  logic [ADDR_W-1:0] br_pc,
    input  logic [ADDR_W-1:0] br_dest,
    input  logic              dir_taken,
    input  logic              dir_guess,
    input  logic              annul_bit,
    input  logic [2:0]        xfer_kind,
    input  logic              was_unpred,
    input  logic              slot_fetched,
    output logic              redirect,
    output logic [ADDR_W-1:0] new_pc,
    output logic [ADDR_W-1:0] new_npc,
    output logic              ckpt_release,
    output logic              ckpt_recover,
    output logic              fetch_unstall,
    output logic              unpred_active
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_BYTES);

    verdict_e          verdict;
    addr_form_e        form;
    logic [ADDR_W-1:0] pc_calc;
    logic [ADDR_W-1:0] npc_calc;
    logic              clear_mode;

    cxr_decide u_decide (
        .was_unpred   (was_unpred),
        .slot_fetched (slot_fetched),
        .annul_bit    (annul_bit),
        .xfer_kind    (xfer_kind),
        .dir_taken    (dir_taken),
        .dir_guess    (dir_guess),
        .verdict      (verdict),
        .form         (form)
    );

    cxr_addr_gen #(
        .ADDR_W     (ADDR_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_addr (
        .br_pc   (br_pc),
        .br_dest (br_dest),
        .form    (form),
        .pc_out  (pc_calc),
        .npc_out (npc_calc)
    );

    assign clear_mode = rsv_valid && (verdict == VERD_UNPRED);

    cxr_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_enter (mode_enter),
        .mode_clear (clear_mode),
        .active     (unpred_active)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect      <= 1'b0;
            ckpt_release  <= 1'b0;
            ckpt_recover  <= 1'b0;
            fetch_unstall <= 1'b0;
            new_pc        <= '0;
            new_npc       <= '0;
        end else begin
            redirect      <= 1'b0;
            ckpt_release  <= 1'b0;
            ckpt_recover  <= 1'b0;
            fetch_unstall <= 1'b0;
            if (rsv_valid) begin
                unique case (verdict)
                    VERD_NONE: ;
                    VERD_GOOD: ckpt_release <= 1'b1;
                    VERD_BAD: begin
                        ckpt_recover <= 1'b1;
                        redirect     <= 1'b1;
                        new_pc       <= pc_calc;
                        new_npc      <= npc_calc;
                    end
                    VERD_UNPRED: begin
                        fetch_unstall <= 1'b1;
                        redirect      <= 1'b1;
                        new_pc        <= pc_calc;
                        new_npc       <= npc_calc;
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ckpt_release, ckpt_recover, fetch_unstall}) <= 1); // R2

    AST_STROBE_NEEDS_RESOLVE: assert property (@(posedge clk) disable iff (!rst_n)
        !rsv_valid |=> !(redirect || ckpt_release || ckpt_recover || fetch_unstall)); // R2

    AST_RELEASE_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_release |-> !redirect); // R7

    AST_RECOVER_REDIRECTS: assert property (@(posedge clk) disable iff (!rst_n)
        ckpt_recover |-> redirect); // R10

    AST_PAIR_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsv_valid && (was_unpred || dir_taken != dir_guess)
         && (was_unpred || (xfer_kind != KIND_DIRECT_A && xfer_kind != KIND_DIRECT_B)))
        |=> ((new_pc == $past(br_dest) && new_npc == $past(br_dest) + STEP) ||
             (new_pc == $past(br_pc) + STEP && new_npc == $past(br_dest)))); // R3

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect && !$past(!rst_n) |-> $stable(new_pc) && $stable(new_npc)); // R2

endmodule

// File: tb/sim_cxr_resolver.sv
module sim_cxr_resolver;

    localparam int AW = 32;
    localparam int NV = 14;

    // [12] unpred [11] slot [10] annul [9:7] kind [6] taken [5] guess
    // [4] redirect [3] release [2] recover [1] unstall [0] slot layout
    localparam logic [12:0] VEC [NV] = '{
        13'b1_1_0_001_1_0_1_0_0_1_0,
        13'b1_0_1_000_1_1_1_0_0_1_0,
        13'b1_0_0_010_1_1_1_0_0_1_1,
        13'b0_1_0_010_1_0_0_0_0_0_0,
        13'b0_0_0_011_0_1_0_0_0_0_0,
        13'b0_1_0_000_1_1_0_1_0_0_0,
        13'b0_0_1_000_0_0_0_1_0_0_0,
        13'b0_0_0_000_1_0_1_0_1_0_1,
        13'b0_1_1_000_1_0_1_0_1_0_1,
        13'b0_1_1_000_0_1_1_0_1_0_0,
        13'b0_1_0_001_1_0_1_0_1_0_0,
        13'b0_1_1_100_1_0_1_0_1_0_0,
        13'b0_0_0_100_0_1_1_0_1_0_1,
        13'b0_1_0_100_1_1_0_1_0_0_0
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_enter = 1'b0;
    logic          rsv_valid = 1'b0;
    logic [AW-1:0] br_pc = '0;
    logic [AW-1:0] br_dest = '0;
    logic          dir_taken = 1'b0;
    logic          dir_guess = 1'b0;
    logic          annul_bit = 1'b0;
    logic [2:0]    xfer_kind = 3'd0;
    logic          was_unpred = 1'b0;
    logic          slot_fetched = 1'b0;
    logic          redirect;
    logic [AW-1:0] new_pc;
    logic [AW-1:0] new_npc;
    logic          ckpt_release;
    logic          ckpt_recover;
    logic          fetch_unstall;
    logic          unpred_active;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cxr_resolver #(.ADDR_W(AW), .INSN_BYTES(4)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_enter(mode_enter), .rsv_valid(rsv_valid),
        .br_pc(br_pc), .br_dest(br_dest), .dir_taken(dir_taken), .dir_guess(dir_guess),
        .annul_bit(annul_bit), .xfer_kind(xfer_kind), .was_unpred(was_unpred),
        .slot_fetched(slot_fetched), .redirect(redirect), .new_pc(new_pc),
        .new_npc(new_npc), .ckpt_release(ckpt_release), .ckpt_recover(ckpt_recover),
        .fetch_unstall(fetch_unstall), .unpred_active(unpred_active)
    );

    task automatic check(input string tag, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic string row_tag(input int i);
        case (i)
            0, 1:       return "R3";
            2:          return "R4";
            3, 4:       return "R6";
            5, 6:       return "R7";
            7:          return "R8";
            8:          return "R9";
            9, 10:      return "R10";
            default:    return "R11";
        endcase
    endfunction

    task automatic strobes_low(input string tag);
        check(tag, "redirect", AW'(redirect), '0);
        check(tag, "release", AW'(ckpt_release), '0);
        check(tag, "recover", AW'(ckpt_recover), '0);
        check(tag, "unstall", AW'(fetch_unstall), '0);
    endtask

    task automatic drive_unpred_resolve();
        rsv_valid = 1'b1; was_unpred = 1'b1; slot_fetched = 1'b1; annul_bit = 1'b0;
        xfer_kind = 3'd0; dir_taken = 1'b1; dir_guess = 1'b1;
        br_pc = 32'h2000; br_dest = 32'h3000;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] exp_pc;
        logic [AW-1:0] exp_npc;
        exp_pc = '0;
        exp_npc = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        strobes_low("R1");
        check("R1", "new_pc", new_pc, '0);
        check("R1", "new_npc", new_npc, '0);
        check("R1", "unpred_active", AW'(unpred_active), '0);
        rst_n = 1'b1;
        @(negedge clk);
        strobes_low("R1");
        check("R1", "new_pc after release", new_pc, '0);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            logic [AW-1:0] bpc;
            logic [AW-1:0] dst;
            v = VEC[i];
            bpc = 32'h1000 + AW'(i * 16);
            dst = 32'h8000 + AW'(i * 32);
            rsv_valid = 1'b1;
            was_unpred = v[12]; slot_fetched = v[11]; annul_bit = v[10];
            xfer_kind = v[9:7]; dir_taken = v[6]; dir_guess = v[5];
            br_pc = bpc; br_dest = dst;
            @(negedge clk);
            rsv_valid = 1'b0;
            if (v[4]) begin
                exp_pc  = v[0] ? bpc + 32'd4 : dst;
                exp_npc = v[0] ? dst : dst + 32'd4;
            end
            check(row_tag(i), "redirect", AW'(redirect), AW'(v[4]));
            check(row_tag(i), "release", AW'(ckpt_release), AW'(v[3]));
            check(row_tag(i), "recover", AW'(ckpt_recover), AW'(v[2]));
            check(v[1] ? "R5" : row_tag(i), "unstall", AW'(fetch_unstall), AW'(v[1]));
            check(v[4] ? row_tag(i) : "R2", "new_pc", new_pc, exp_pc);
            check(v[4] ? row_tag(i) : "R2", "new_npc", new_npc, exp_npc);
        end

        // R2: single-cycle strobes, idle gives nothing
        @(negedge clk);
        strobes_low("R2");
        check("R2", "held new_pc", new_pc, exp_pc);

        // R12: enter mode
        mode_enter = 1'b1;
        @(negedge clk);
        mode_enter = 1'b0;
        check("R12", "unpred_active", AW'(unpred_active), 32'd1);
        @(negedge clk);
        check("R12", "unpred_active held", AW'(unpred_active), 32'd1);

        // R5: unpredicted resolve clears mode and pulses unstall
        drive_unpred_resolve();
        @(negedge clk);
        rsv_valid = 1'b0; was_unpred = 1'b0;
        check("R5", "unpred_active", AW'(unpred_active), '0);
        check("R5", "unstall", AW'(fetch_unstall), 32'd1);
        check("R5", "release", AW'(ckpt_release), '0);
        check("R5", "new_pc", new_pc, 32'h3000);

        // R12: enter coincides with unpredicted resolve
        mode_enter = 1'b1;
        @(negedge clk);
        mode_enter = 1'b0;
        drive_unpred_resolve();
        mode_enter = 1'b1;
        @(negedge clk);
        rsv_valid = 1'b0; was_unpred = 1'b0; mode_enter = 1'b0;
        check("R12", "active after collision", AW'(unpred_active), 32'd1);
        check("R12", "unstall on collision", AW'(fetch_unstall), 32'd1);

        // R7: reserved kind acts as a checked jump
        rsv_valid = 1'b1; xfer_kind = 3'd6; dir_taken = 1'b0; dir_guess = 1'b0;
        slot_fetched = 1'b1; annul_bit = 1'b0;
        @(negedge clk);
        rsv_valid = 1'b0;
        check("R7", "reserved kind release", AW'(ckpt_release), 32'd1);
        check("R7", "reserved kind redirect", AW'(redirect), '0);
        @(negedge clk);
        strobes_low("R2");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule